// File: doc/BRIEF.md
# Multi-Lane Signal-Detect Qualifier with Squelch

This block sits on the receive side of a twelve-lane parallel link. Every lane delivers a raw "light present" bit, sampled once per clock, together with a narrow data word. The block filters each raw bit into a qualified per-lane signal-detect flag. A flag changes state only after the raw bit has disagreed with it for a set number of consecutive cycles. The count needed to set the flag and the count needed to clear it are separate parameters.

The per-lane flags are combined into one link-level status. That status is high only when every lane is qualified. When the squelch control is high, the data word of each unqualified lane is replaced by an all-zero idle word, and qualified lanes pass their data unchanged. A receiver-enable input switches the whole receiver. It must stay high for a long, parameterised number of cycles before the receiver turns on, and it turns the receiver off after a much shorter low interval. While the receiver is off, all status and data outputs sit at zero.

Top module: `rx_lane_monitor`

## Requirements
- R1: A lane's qualified flag rises only after that lane's raw present bit has been high for SET_CYCLES consecutive clock edges while the flag was low. A high pulse shorter than that leaves the flag low.
- R2: A lane's qualified flag falls only after the raw bit has been low for CLEAR_CYCLES consecutive edges while the flag was high. A shorter low glitch leaves the flag high.
- R3: `link_sd` is high exactly when the receiver is on and all LANES qualified flags are high. It goes low when any single lane loses qualification.
- R4: With `squelch_en` high and the receiver on, every lane whose qualified flag is low outputs the zero word. Every other lane outputs its input word unchanged. Lane i occupies bits [i*DATA_W +: DATA_W] of both data buses.
- R5: With `squelch_en` low and the receiver on, every lane passes its input word unchanged, whatever its flag.
- R6: The receiver turns on only after `rx_enable` has been high for ON_CYCLES consecutive edges while it was off. A shorter high interval leaves it off.
- R7: The receiver turns off after `rx_enable` has been low for OFF_CYCLES consecutive edges while it was on. While it is off, `link_sd`, every bit of `lane_sd` and the whole data bus are zero.
- R8: After a synchronous active-low reset, all qualified flags are low, the receiver is off and all outputs are zero.
- R9: A lane's data is muted in the same cycle in which its `lane_sd` bit falls, provided squelch is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_enable | input | 1 | Receiver enable, active high |
| squelch_en | input | 1 | Mute unqualified lanes when high |
| lane_present | input | LANES | Raw per-lane signal-present bits |
| lane_din | input | LANES*DATA_W | Per-lane data words, lane i at [i*DATA_W +: DATA_W] |
| lane_dout | output | LANES*DATA_W | Gated per-lane data words |
| lane_sd | output | LANES | Qualified per-lane signal detect, low while receiver is off |
| link_sd | output | 1 | All-lanes-qualified status |

## Verification
The assertions assume that the raw present bits and `rx_enable` are synchronous to `clk`, so their stability is judged per edge with no metastability filtering. They also assume that reset is held low at the first clock edge. The bench therefore drives every input on the falling edge and holds reset low for several edges at start. It changes `squelch_en` and the data words only between edges. This works because the muting path is combinational from those inputs, so their effect can be observed without waiting for a clock edge.

// File: rtl/rxmon_pkg.sv
// Package rxmon_pkg
// Shared helpers for the lane monitor: counter sizing for the level filters.
// Assumes every cycle count handed to it is at least 1.
package rxmon_pkg;

    // Width needed to hold values 0 .. n-1 (at least one bit).
    function automatic int unsigned cnt_width(input int unsigned n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

    // Larger of two counts.
    function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rxmon_level_filter.sv
// Module rxmon_level_filter
// Asymmetric persistence filter. The output follows the input only after the
// input has disagreed with it on RISE_CYC consecutive edges (output low) or
// FALL_CYC consecutive edges (output high). Any agreeing sample restarts the
// run. Used for both the lane detect flags and the receiver-enable sequencing.
// Assumes level_in is synchronous to clk and both counts are at least 1.
module rxmon_level_filter #(
    parameter int unsigned RISE_CYC = 8,
    parameter int unsigned FALL_CYC = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_in,
    output logic level_q
);
    import rxmon_pkg::*;

    localparam int unsigned MAX_CYC = max_of(RISE_CYC, FALL_CYC);
    localparam int unsigned CW      = cnt_width(MAX_CYC);
    localparam logic [CW-1:0] RISE_LAST = CW'(RISE_CYC - 1);
    localparam logic [CW-1:0] FALL_LAST = CW'(FALL_CYC - 1);

    logic [CW-1:0] run_cnt;
    logic [CW-1:0] run_last;
    logic          mismatch;

    // Select the run length that applies to the current output state.
    always_comb begin
        run_last = level_q ? FALL_LAST : RISE_LAST;
        mismatch = (level_in != level_q);
    end

    // Count consecutive disagreeing samples and flip the output on the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= 1'b0;
            run_cnt <= '0;
        end else if (!mismatch) begin
            run_cnt <= '0;
        end else if (run_cnt == run_last) begin
            level_q <= level_in;
            run_cnt <= '0;
        end else begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    // R1 R2
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level_in == level_q) |=> $stable(level_q));

    // R1 R2
    run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_cnt <= CW'(MAX_CYC - 1));

    // R1 R2
    flip_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level_q != $past(level_q)) |-> (level_q == $past(level_in)));

endmodule

// File: rtl/rxmon_sd_combine.sv
// Module rxmon_sd_combine
// Gates the qualified lane flags with the receiver-on state and forms the
// link-level status as the AND of all lanes. Purely combinational.
// Assumes rx_on and lane_flag come from registers in the same clock domain.
module rxmon_sd_combine #(
    parameter int unsigned LANES = 12
) (
    input  logic             rx_on,
    input  logic [LANES-1:0] lane_flag,
    output logic [LANES-1:0] lane_sd,
    output logic             link_sd
);
    // Publish per-lane flags only while the receiver is on; reduce to link status.
    always_comb begin
        lane_sd = rx_on ? lane_flag : '0;
        link_sd = rx_on & (&lane_flag);
    end

endmodule

// File: rtl/rxmon_lane_mute.sv
// Module rxmon_lane_mute
// Output gate for one lane. It passes the input word when the receiver is on
// and the lane is either qualified or squelch is disabled; otherwise it drives
// the zero idle word. Purely combinational, so muting tracks the flag in the
// same cycle.
// Assumes all inputs are synchronous to the consumer's clock.
module rxmon_lane_mute #(
    parameter int unsigned DATA_W = 2
) (
    input  logic              rx_on,
    input  logic              squelch_en,
    input  logic              lane_ok,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    logic pass;

    // Decide whether this lane's word reaches the output.
    always_comb begin
        pass = rx_on & (lane_ok | ~squelch_en);
        dout = pass ? din : '0;
    end

endmodule

// File: rtl/rx_lane_monitor.sv
// Module rx_lane_monitor
// Receive-side signal-detect qualifier for a multi-lane parallel link.
// Each lane's raw present bit is filtered into a qualified flag. The flags are
// AND-reduced into a link status, and unqualified lanes are muted when
// squelch is enabled. A receiver enable with a long turn-on and a short
// turn-off window gates everything.
// Assumes all inputs are synchronous to clk; reset is synchronous, active low.
module rx_lane_monitor #(
    parameter int unsigned LANES      = 12,
    parameter int unsigned DATA_W     = 2,
    parameter int unsigned SET_CYCLES = 8,
    parameter int unsigned CLR_CYCLES = 5,
    parameter int unsigned ON_CYCLES  = 30,
    parameter int unsigned OFF_CYCLES = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rx_enable,
    input  logic                     squelch_en,
    input  logic [LANES-1:0]         lane_present,
    input  logic [LANES*DATA_W-1:0]  lane_din,
    output logic [LANES*DATA_W-1:0]  lane_dout,
    output logic [LANES-1:0]         lane_sd,
    output logic                     link_sd
);
    localparam int unsigned BUS_W = LANES * DATA_W;

    logic             rx_on;
    logic [LANES-1:0] lane_flag;

    // Receiver-enable sequencing: long rise window, short fall window.
    rxmon_level_filter #(
        .RISE_CYC (ON_CYCLES),
        .FALL_CYC (OFF_CYCLES)
    ) u_enable_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .level_in (rx_enable),
        .level_q  (rx_on)
    );

    // One qualifier and one output gate per lane.
    for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
        rxmon_level_filter #(
            .RISE_CYC (SET_CYCLES),
            .FALL_CYC (CLR_CYCLES)
        ) u_qual (
            .clk      (clk),
            .rst_n    (rst_n),
            .level_in (lane_present[gi]),
            .level_q  (lane_flag[gi])
        );

        rxmon_lane_mute #(
            .DATA_W (DATA_W)
        ) u_mute (
            .rx_on      (rx_on),
            .squelch_en (squelch_en),
            .lane_ok    (lane_flag[gi]),
            .din        (lane_din[gi*DATA_W +: DATA_W]),
            .dout       (lane_dout[gi*DATA_W +: DATA_W])
        );

        // R4
        mute_lost_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rx_on && squelch_en && !lane_flag[gi]) |-> (lane_dout[gi*DATA_W +: DATA_W] == '0));

        // R4
        pass_good_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rx_on && lane_sd[gi]) |-> (lane_dout[gi*DATA_W +: DATA_W] == lane_din[gi*DATA_W +: DATA_W]));

        // R5
        no_squelch_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rx_on && !squelch_en) |-> (lane_dout[gi*DATA_W +: DATA_W] == lane_din[gi*DATA_W +: DATA_W]));

        // R9
        same_cycle_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($fell(lane_sd[gi]) && rx_on && squelch_en) |-> (lane_dout[gi*DATA_W +: DATA_W] == '0));
    end

    // Status gating and link-level reduction.
    rxmon_sd_combine #(
        .LANES (LANES)
    ) u_combine (
        .rx_on     (rx_on),
        .lane_flag (lane_flag),
        .lane_sd   (lane_sd),
        .link_sd   (link_sd)
    );

    // R3
    link_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_sd |-> (&lane_sd));

    // R3
    link_any_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_sd != {LANES{1'b1}}) |-> !link_sd);

    // R7
    idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_on |-> (lane_dout == {BUS_W{1'b0}} && lane_sd == '0 && !link_sd));

    // R6
    on_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_on) |-> $past(rx_enable));

    // R7
    off_needs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_on) |-> !$past(rx_enable));

endmodule

// File: tb/rx_lane_monitor_bench.sv
// Directed bench for rx_lane_monitor. Inputs change on falling edges and
// outputs are checked on falling edges, half a period away from the active edge.
module rx_lane_monitor_bench;
    localparam int unsigned LANES  = 12;
    localparam int unsigned DW     = 2;
    localparam int unsigned SETC   = 8;
    localparam int unsigned CLRC   = 5;
    localparam int unsigned ONC    = 30;
    localparam int unsigned OFFC   = 3;
    localparam int unsigned BW     = LANES * DW;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             rx_enable;
    logic             squelch_en;
    logic [LANES-1:0] lane_present;
    logic [BW-1:0]    lane_din;
    logic [BW-1:0]    lane_dout;
    logic [LANES-1:0] lane_sd;
    logic             link_sd;

    int unsigned n_vec = 0;
    int unsigned n_bad = 0;
    bit          finished = 1'b0;

    logic [LANES-1:0] exp_fl;
    bit               exp_on;

    always #5 clk = ~clk;

    rx_lane_monitor #(
        .LANES(LANES), .DATA_W(DW), .SET_CYCLES(SETC), .CLR_CYCLES(CLRC),
        .ON_CYCLES(ONC), .OFF_CYCLES(OFFC)
    ) u_rx_lane_monitor (
        .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .squelch_en(squelch_en),
        .lane_present(lane_present), .lane_din(lane_din), .lane_dout(lane_dout),
        .lane_sd(lane_sd), .link_sd(link_sd)
    );

    task automatic tick(input int unsigned n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cmp(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Compare all outputs with values computed from exp_fl, exp_on and the drives.
    task automatic check_state(input string req);
        logic [BW-1:0] want;
        want = '0;
        for (int i = 0; i < LANES; i++) begin
            if (exp_on && (!squelch_en || exp_fl[i]))
                want[i*DW +: DW] = lane_din[i*DW +: DW];
        end
        cmp(req, "lane_sd", 64'(lane_sd), 64'(exp_on ? exp_fl : '0));
        cmp(req, "link_sd", 64'(link_sd), 64'(exp_on && (&exp_fl)));
        cmp(req, "lane_dout", 64'(lane_dout), 64'(want));
    endtask

    task automatic t_reset();
        rst_n = 1'b0; rx_enable = 1'b1; squelch_en = 1'b0;
        lane_present = '1; lane_din = 24'hC3C3C3;
        exp_fl = '0; exp_on = 1'b0;
        tick(3);
        check_state("R8");
        rst_n = 1'b1;
    endtask

    task automatic t_power_on();
        tick(ONC - 1);
        exp_fl = '1;
        check_state("R6");
        tick(1);
        exp_on = 1'b1;
        check_state("R6");
        check_state("R3");
        lane_din = 24'h5A3C96;
        #1 check_state("R5");
    endtask

    task automatic t_enable_windows();
        rx_enable = 1'b0;
        tick(OFFC - 1);
        check_state("R7");
        rx_enable = 1'b1;
        tick(2);
        check_state("R7");
        rx_enable = 1'b0;
        tick(OFFC - 1);
        check_state("R7");
        tick(1);
        exp_on = 1'b0;
        check_state("R7");
        rx_enable = 1'b1;
        tick(ONC - 1);
        check_state("R6");
        rx_enable = 1'b0;
        tick(2);
        check_state("R6");
        rx_enable = 1'b1;
        tick(ONC);
        exp_on = 1'b1;
        check_state("R6");
    endtask

    task automatic t_lane_loss();
        squelch_en = 1'b1;
        lane_din = 24'hFFFFFF;
        lane_present[3] = 1'b0;
        tick(CLRC - 1);
        check_state("R2");
        tick(1);
        exp_fl[3] = 1'b0;
        check_state("R9");
        check_state("R4");
        lane_din = 24'hC3C3C3;
        #1 check_state("R4");
        lane_present[5] = 1'b0;
        tick(CLRC - 1);
        lane_present[5] = 1'b1;
        tick(2);
        check_state("R2");
    endtask

    task automatic t_lane_return();
        lane_present[3] = 1'b1;
        tick(SETC - 1);
        check_state("R1");
        lane_present[3] = 1'b0;
        tick(2);
        check_state("R1");
        lane_present[3] = 1'b1;
        tick(SETC);
        exp_fl[3] = 1'b1;
        check_state("R1");
        check_state("R3");
    endtask

    task automatic t_squelch_toggle();
        lane_din = 24'hFFFFFF;
        lane_present[7] = 1'b0;
        lane_present[0] = 1'b0;
        lane_present[11] = 1'b0;
        tick(CLRC);
        exp_fl[7] = 1'b0; exp_fl[0] = 1'b0; exp_fl[11] = 1'b0;
        check_state("R4");
        squelch_en = 1'b0;
        #1 check_state("R5");
        lane_din = 24'hC3C3C3;
        #1 check_state("R5");
        squelch_en = 1'b1;
        #1 check_state("R4");
        rx_enable = 1'b0;
        tick(OFFC);
        exp_on = 1'b0;
        check_state("R7");
    endtask

    initial begin
        t_reset();
        t_power_on();
        t_enable_windows();
        t_lane_loss();
        t_lane_return();
        t_squelch_toggle();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule